// File: doc/BRIEF.md
# Absolute-Difference Accumulate Execution Slice

This slice executes a small group of integer multimedia operations. Each cycle it takes a 32-bit instruction word and three 64-bit operand values. The first two operands are the sources. The third is the current value of the destination register, which only the accumulate forms use. It decodes the word, computes the result and registers the result together with its side effects. Those side effects are a register write-enable, a 3-bit condition field with its own enable, and an illegal-instruction flag. Every output appears one clock edge after the inputs are presented.

Four operations share one primary opcode:
- a rounded average of the two sources;
- an unsigned absolute difference;
- an unsigned absolute-difference accumulate;
- a signed absolute-difference accumulate.

The two accumulate forms add the absolute difference of the sources to the destination value and wrap modulo 2^64. A record bit in the word asks for the condition field to be written.

Top module: `absdiff_acc_slice`

## Requirements
- R1: A word whose top six bits (insn_i[31:26]) are not 22 produces no register write, no condition write and no illegal flag.
- R2: With extended opcode insn_i[10:1] = 0b1011110110, the result is the unsigned absolute difference |ra_i − rb_i|, and wr_en_o is 1.
- R3: With extended opcode 0b1101001110, the result is (ra_i + rb_i + 1) >> 1, computed on 65 bits so that the carry out of bit 63 is kept.
- R4: With extended opcode 0b1111110110, the result is rt_i plus the unsigned absolute difference of ra_i and rb_i, modulo 2^64. An all-ones source counts as the largest value.
- R5: With extended opcode 0b0111110110, the result is rt_i plus the absolute difference with both sources taken as two's complement, modulo 2^64. For example, ra_i = 2 and rb_i = −1 add 3.
- R6: When the record bit insn_i[0] is 1 and the word writes a register, cr_en_o is 1 and cr_o = {LT, GT, EQ}. LT is the sign bit of the result, EQ means the result is zero, and GT means neither. Otherwise cr_en_o is 0 and cr_o is 0.
- R7: A primary opcode of 22 with any other extended opcode sets illegal_o and holds wr_en_o and cr_en_o at 0.
- R8: All outputs are registered with one cycle of latency. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| ra_i | input | 64 | First source operand |
| rb_i | input | 64 | Second source operand |
| rt_i | input | 64 | Current destination value (accumulator input) |
| result_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Destination write enable |
| cr_o | output | 3 | Condition field {LT, GT, EQ} |
| cr_en_o | output | 1 | Condition field write enable |
| illegal_o | output | 1 | Unknown extended opcode under the primary opcode |

## Verification
The bench targets the cases where the chosen ordering changes the answer. With one source all-ones and the other 2, the unsigned forms must add 0xFFFF_FFFF_FFFF_FFFD and the signed form must add 3. A slice that mixed up the two orderings returns one of these values in place of the other.

An accumulator near all-ones must wrap to a small value. If the accumulate add were saturating or too narrow, the result would stick at the top or lose bits. Averaging two all-ones operands must return all-ones. If the average dropped the carry, the result would come out halved.

Equal operands must yield zero with EQ set. Unknown extended opcodes and foreign primary opcodes must leave the write and condition enables low, even with the record bit set. A decoder that let these through would corrupt a register.

// File: rtl/adas_pkg.sv
package adas_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned PO_W   = 6;
  localparam int unsigned XO_W   = 10;
  localparam int unsigned CR_W   = 3;

  localparam logic [PO_W-1:0] PO_MM   = 6'd22;
  localparam logic [XO_W-1:0] XO_ABSD = 10'b1011110110;
  localparam logic [XO_W-1:0] XO_AVG  = 10'b1101001110;
  localparam logic [XO_W-1:0] XO_ACCU = 10'b1111110110;
  localparam logic [XO_W-1:0] XO_ACCS = 10'b0111110110;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ABSD,
    OP_AVG,
    OP_ACCU,
    OP_ACCS
  } op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cond_t;
endpackage

// File: rtl/adas_decode.sv
module adas_decode
  import adas_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output op_e               op_o,
  output logic              hit_o,
  output logic              rc_o,
  output logic              illegal_o,
  output logic              signed_o
);
  logic [PO_W-1:0] po;
  logic [XO_W-1:0] xo;

  // primary opcode occupies the most significant bits, XO sits above the record bit
  assign po   = insn_i[INSN_W-1 -: PO_W];
  assign xo   = insn_i[XO_W:1];
  assign rc_o = insn_i[0];

  always_comb begin
    op_o      = OP_NONE;
    illegal_o = 1'b0;
    if (po == PO_MM) begin
      unique case (xo)
        XO_ABSD: op_o = OP_ABSD;
        XO_AVG:  op_o = OP_AVG;
        XO_ACCU: op_o = OP_ACCU;
        XO_ACCS: op_o = OP_ACCS;
        default: illegal_o = 1'b1;
      endcase
    end
  end

  assign hit_o    = (op_o != OP_NONE);
  assign signed_o = (op_o == OP_ACCS);
endmodule

// File: rtl/adas_absdiff.sv
module adas_absdiff #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  output logic [W-1:0] diff_o
);
  logic a_lt_b;

  // flipping the sign bits maps two's complement order onto unsigned order
  logic [W-1:0] a_k, b_k;
  assign a_k    = {a_i[W-1] ^ signed_i, a_i[W-2:0]};
  assign b_k    = {b_i[W-1] ^ signed_i, b_i[W-2:0]};
  assign a_lt_b = (a_k < b_k);
  assign diff_o = a_lt_b ? (b_i - a_i) : (a_i - b_i);
endmodule

// File: rtl/adas_exec.sv
module adas_exec
  import adas_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  op_e          op_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] diff_o
);
  localparam int unsigned SW = W + 1;

  logic [SW-1:0] avg_sum;
  logic [W-1:0]  avg;

  adas_absdiff #(.W(W)) u_absdiff (
    .a_i      (a_i),
    .b_i      (b_i),
    .signed_i (signed_i),
    .diff_o   (diff_o)
  );

  assign avg_sum = {1'b0, a_i} + {1'b0, b_i} + SW'(1);
  assign avg     = avg_sum[SW-1:1];

  always_comb begin
    unique case (op_i)
      OP_ABSD:          res_o = diff_o;
      OP_AVG:           res_o = avg;
      OP_ACCU, OP_ACCS: res_o = acc_i + diff_o;
      default:          res_o = '0;
    endcase
  end
endmodule

// File: rtl/adas_cond.sv
module adas_cond
  import adas_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] val_i,
  output cond_t        cond_o
);
  assign cond_o.lt = val_i[W-1];
  assign cond_o.eq = (val_i == '0);
  assign cond_o.gt = !cond_o.lt && !cond_o.eq;
endmodule

// File: rtl/absdiff_acc_slice.sv
module absdiff_acc_slice
  import adas_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   ra_i,
  input  logic [XLEN-1:0]   rb_i,
  input  logic [XLEN-1:0]   rt_i,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic [CR_W-1:0]   cr_o,
  output logic              cr_en_o,
  output logic              illegal_o
);
  op_e             op;
  logic            hit, rc, illegal, sgn;
  logic [XLEN-1:0] res, diff;
  cond_t           cond;

  adas_decode u_decode (
    .insn_i    (insn_i),
    .op_o      (op),
    .hit_o     (hit),
    .rc_o      (rc),
    .illegal_o (illegal),
    .signed_o  (sgn)
  );

  adas_exec #(.W(XLEN)) u_exec (
    .op_i     (op),
    .signed_i (sgn),
    .a_i      (ra_i),
    .b_i      (rb_i),
    .acc_i    (rt_i),
    .res_o    (res),
    .diff_o   (diff)
  );

  adas_cond #(.W(XLEN)) u_cond (
    .val_i  (res),
    .cond_o (cond)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      cr_o      <= '0;
      cr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= res;
      wr_en_o   <= hit;
      cr_o      <= (hit && rc) ? cond : '0;
      cr_en_o   <= hit && rc;
      illegal_o <= illegal;
    end
  end

  assert_foreign_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_i[INSN_W-1 -: PO_W] != PO_MM) |=> (!wr_en_o && !cr_en_o && !illegal_o));

  assert_illegal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !cr_en_o));

  assert_cr_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_en_o |-> ($countones(cr_o) == 1 && wr_en_o));

  assert_cr_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_en_o |-> (cr_o == '0));

  assert_cr_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_en_o |-> (cr_o[CR_W-1] == result_o[XLEN-1]));

  assert_acc_uses_diff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ACCU || op == OP_ACCS) |=> (result_o - $past(rt_i) == $past(diff)));
endmodule

// File: tb/tb_absdiff_acc_slice.sv
`timescale 1ns/1ps
module tb_absdiff_acc_slice;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] ra_i = '0, rb_i = '0, rt_i = '0;
  logic [63:0] result_o;
  logic        wr_en_o, cr_en_o, illegal_o;
  logic [2:0]  cr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [9:0] X_ABSD = 10'b1011110110;
  localparam logic [9:0] X_AVG  = 10'b1101001110;
  localparam logic [9:0] X_ACCU = 10'b1111110110;
  localparam logic [9:0] X_ACCS = 10'b0111110110;
  localparam logic [63:0] ONES  = '1;

  always #2.5 clk_i = ~clk_i;

  absdiff_acc_slice dut (
    .clk_i, .rst_ni, .insn_i, .ra_i, .rb_i, .rt_i,
    .result_o, .wr_en_o, .cr_o, .cr_en_o, .illegal_o
  );

  function automatic logic [31:0] mk(logic [5:0] po, logic [9:0] xo, logic rc);
    return {po, 5'd3, 5'd1, 5'd2, xo, rc};
  endfunction

  function automatic logic [63:0] absd(logic [63:0] a, logic [63:0] b, bit s);
    bit lt;
    lt = s ? ($signed(a) < $signed(b)) : (a < b);
    return lt ? b - a : a - b;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] w, logic [63:0] a, logic [63:0] b, logic [63:0] c);
    logic [63:0] e_res;
    logic e_wr, e_ill, e_cren;
    logic [2:0] e_cr;
    logic [64:0] s;
    string req;
    e_res = '0; e_wr = 0; e_ill = 0; req = "R1";
    if (w[31:26] == 6'd22) begin
      e_wr = 1;
      case (w[10:1])
        X_ABSD: begin e_res = absd(a, b, 0); req = "R2"; end
        X_AVG:  begin s = {1'b0, a} + {1'b0, b} + 65'd1; e_res = s[64:1]; req = "R3"; end
        X_ACCU: begin e_res = c + absd(a, b, 0); req = "R4"; end
        X_ACCS: begin e_res = c + absd(a, b, 1); req = "R5"; end
        default: begin e_wr = 0; e_ill = 1; req = "R7"; end
      endcase
    end
    e_cren = e_wr && w[0];
    e_cr = e_cren ? {e_res[63], !e_res[63] && e_res != 0, e_res == 0} : 3'b000;
    @(negedge clk_i);
    insn_i = w; ra_i = a; rb_i = b; rt_i = c;
    @(posedge clk_i);
    #1;
    if (e_wr) check(req, result_o, e_res);
    check({req, " wr"}, {63'd0, wr_en_o}, {63'd0, e_wr});
    check({req, " ill"}, {63'd0, illegal_o}, {63'd0, e_ill});
    check("R6 cr_en", {63'd0, cr_en_o}, {63'd0, e_cren});
    check("R6 cr", {61'd0, cr_o}, {61'd0, e_cr});
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk_i);
    #1;
    // R8: outputs zero while reset is held
    check("R8 res", result_o, '0);
    check("R8 flags", {60'd0, wr_en_o, cr_en_o, illegal_o, |cr_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    run(mk(6'd22, X_ABSD, 1), 64'd77, 64'd77, 64'd0);
    run(mk(6'd22, X_ACCS, 1), 64'd2, ONES, 64'd0);
    run(mk(6'd22, X_ACCS, 1), 64'd10, 64'd4, 64'd3);
    run(mk(6'd22, X_ACCU, 1), 64'd2, ONES, 64'd0);
    run(mk(6'd22, X_ABSD, 0), ONES, 64'd2, 64'd0);
    run(mk(6'd22, X_ACCU, 1), 64'd5, 64'd3, ONES);
    run(mk(6'd22, X_ACCS, 1), 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    run(mk(6'd22, X_AVG, 1), ONES, ONES, 64'd0);
    run(mk(6'd22, X_AVG, 0), 64'd4, 64'd7, 64'd0);
    run(mk(6'd22, 10'h3FF, 1), 64'd1, 64'd2, 64'd3);
    run(mk(6'd31, X_ACCU, 1), 64'd1, 64'd9, 64'd3);
    run(mk(6'd23, X_ABSD, 1), 64'd1, 64'd9, 64'd3);

    for (int i = 0; i < 400; i++) begin
      logic [9:0]  xo;
      logic [5:0]  po;
      logic [63:0] a, b, c;
      int unsigned k;
      k = $urandom % 6;
      po = 6'd22;
      case (k)
        0: xo = X_ABSD;
        1: xo = X_AVG;
        2: xo = X_ACCU;
        3: xo = X_ACCS;
        4: xo = 10'($urandom);
        default: begin xo = X_ACCU; po = 6'($urandom); end
      endcase
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      c = {$urandom, $urandom};
      if ($urandom % 5 == 0) a = ONES;
      if ($urandom % 5 == 0) b = a;
      run(mk(po, xo, 1'($urandom)), a, b, c);
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule